// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO with Almost Flags

This block buffers words between a write clock domain and an independent read clock domain. A timing mode is captured while the master reset is held. In standard mode the reader asks for every word, including the first, by holding its read enable low on a read-clock edge. In fall-through mode the oldest word is moved onto the output without a request, and a registered output stage holds it until it is consumed. That output stage adds one word of capacity, so the threshold counts move by one.

Pointers cross between the domains as Gray code through two-flop synchronizers. The write side counts the words in the storage array against the synchronized read pointer. The read side counts against the synchronized write pointer. A flag therefore asserts on the same edge as the local event that causes it, and it releases only after the remote pointer has been synchronized. The almost-empty offset (default 2) and the almost-full offset (default 3) are parameters loaded into registers at reset. The memory depth (default 16, a power of two) and the word width (default 8) are parameters.

The read controller is a state machine with four states. It leaves `RD_RESET` on the first read-clock edge after reset release. It goes to `RD_STD` when the captured mode is standard, and it stays there. It goes to `RD_FW_EMPTY` when the captured mode is fall-through. From `RD_FW_EMPTY`, the transition "fill" goes to `RD_FW_HOLD` as soon as the array holds a word, and that word is loaded into the output. From `RD_FW_HOLD`, a read with the array empty takes the transition "drain" back to `RD_FW_EMPTY`. A read with a word waiting takes "reload": the state stays in `RD_FW_HOLD` and the next word is loaded. Without a read, the state stays in `RD_FW_HOLD` and the word is held.

Top module: `fifo_dual_clock`

## Requirements
- R1: `mode_fwft` is sampled only on clock edges while `mrst_n` is low. 0 selects standard mode and 1 selects fall-through mode. Changing it after reset release has no effect until the next reset.
- R2: In standard mode, `dout` takes the oldest stored word on the read-clock edge where `ren_n` is low and a word is stored. The first word is also delivered only this way. Otherwise `dout` holds its value, and it is 0 after reset.
- R3: In fall-through mode, a word written into an empty FIFO appears on `dout` on the third read-clock rising edge after the write edge, with `ren_n` high. The word stays on `dout` until a read-clock edge with `ren_n` low.
- R4: In standard mode, `rd_stat` is an active-low empty flag: it is 0 while nothing is stored and 1 once a word is stored. `wr_full_n` is 0 once DEPTH words are stored.
- R5: In fall-through mode, `rd_stat` is 0 while a valid word is on `dout` and 1 when the FIFO holds nothing. `wr_full_n` is 0 once DEPTH+1 words are held.
- R6: `almost_empty_n` is 1 when the occupancy is at least N+1 in standard mode, or at least N+2 in fall-through mode, and 0 otherwise. N is the almost-empty offset.
- R7: `almost_full_n` is 0 when the occupancy is at least DEPTH−M in standard mode, or at least DEPTH+1−M in fall-through mode, and 1 otherwise. M is the almost-full offset.
- R8: A write while `wr_full_n` is 0 is discarded. The first read from a full FIFO brings `wr_full_n` back to 1.
- R9: A read request while the FIFO is empty is ignored. `dout` keeps its value, and `rd_stat` keeps its empty value.
- R10: Words leave in the order they were written, including when the pointers wrap past the end of the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assertion |
| mode_fwft | input | 1 | Mode select sampled during reset: 0 standard, 1 fall-through |
| wen_n | input | 1 | Write enable, active low, wclk domain |
| din | input | WIDTH | Write data |
| ren_n | input | 1 | Read enable, active low, rclk domain |
| dout | output | WIDTH | Read data register |
| rd_stat | output | 1 | Empty flag (standard) or output-ready flag (fall-through), active low |
| wr_full_n | output | 1 | Full flag (standard) or input-ready flag (fall-through), low when no space is left |
| almost_empty_n | output | 1 | Almost-empty flag, low when near empty, rclk domain |
| almost_full_n | output | 1 | Almost-full flag, low when near full, wclk domain |

## Verification
Local effects appear one edge after the stimulus. This covers `dout` in standard mode, `wr_full_n` after a write and `rd_stat` after a read. Effects that travel to the other domain need two synchronizer edges. Fall-through data and `rd_stat` need one more edge, so they are due on the third read-clock edge after the write edge. The bench samples that case at one nanosecond past the second and the third read-clock edges, and it expects the word to be missing and then present. Every other flag check is made after a settle window of eight read-clock cycles. Data and flags are sampled on falling edges, so each due edge is already behind the sample point.

// File: rtl/fifo_dual_pkg.sv
`timescale 1ns/1ps
package fifo_dual_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

    typedef enum logic [1:0] {
        RD_RESET    = 2'd0,
        RD_STD      = 2'd1,
        RD_FW_EMPTY = 2'd2,
        RD_FW_HOLD  = 2'd3
    } rd_state_e;

endpackage

// File: rtl/sync_stages.sv
`timescale 1ns/1ps
module sync_stages #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/dual_ram.sv
`timescale 1ns/1ps
module dual_ram #(
    parameter int W  = 8,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int WORDS = 1 << AW;

    logic [W-1:0] mem [WORDS];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_wr_ctl.sv
`timescale 1ns/1ps
module fifo_wr_ctl #(
    parameter int AW       = 4,
    parameter int OFFSET_M = 3
) (
    input  logic          wclk,
    input  logic          mrst_n,
    input  logic          wen_n,
    input  logic [AW:0]   rgray_sync,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] waddr,
    output logic          push,
    output logic          full_n,
    output logic          afull_n
);
    localparam logic [AW:0] DEPTH_P = (AW+1)'(1 << AW);
    localparam logic [AW:0] OFF_M   = (AW+1)'(OFFSET_M);

    logic [AW:0] wbin, wbin_nx, rbin, count, m_q;
    logic        full;

    always_comb begin
        for (int i = 0; i <= AW; i++) rbin[i] = ^(rgray_sync >> i);
    end

    assign count   = wbin - rbin;
    assign full    = (count == DEPTH_P);
    assign push    = !wen_n && !full;
    assign wbin_nx = wbin + (AW+1)'(push);
    assign waddr   = wbin[AW-1:0];
    assign full_n  = !full;
    assign afull_n = !(count >= (DEPTH_P - m_q));

    always_ff @(posedge wclk or negedge mrst_n) begin
        if (!mrst_n) begin
            wbin  <= '0;
            wgray <= '0;
            m_q   <= OFF_M;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
            m_q   <= m_q;
        end
    end

    assert_count_bound_R8: assert property (@(posedge wclk) disable iff (!mrst_n)
        count <= DEPTH_P);

    assert_no_write_when_full_R8: assert property (@(posedge wclk) disable iff (!mrst_n)
        (!full_n && !wen_n) |=> $stable(wbin));
endmodule

// File: rtl/fifo_rd_ctl.sv
`timescale 1ns/1ps
module fifo_rd_ctl
    import fifo_dual_pkg::*;
#(
    parameter int W        = 8,
    parameter int AW       = 4,
    parameter int OFFSET_N = 2
) (
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          mode_i,
    input  logic          ren_n,
    input  logic [AW:0]   wgray_sync,
    input  logic [W-1:0]  rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [W-1:0]  dout,
    output logic          rd_stat,
    output logic          aempty_n
);
    localparam logic [AW:0] DEPTH_P = (AW+1)'(1 << AW);
    localparam logic [AW:0] OFF_N   = (AW+1)'(OFFSET_N);

    fifo_mode_e  mode_q;
    rd_state_e   state, state_nx;
    logic [AW:0] rbin, rbin_nx, wbin, mem_cnt, n_q;
    logic        mem_empty, pop;

    always_comb begin
        for (int i = 0; i <= AW; i++) wbin[i] = ^(wgray_sync >> i);
    end

    assign mem_cnt   = wbin - rbin;
    assign mem_empty = (mem_cnt == '0);
    assign raddr     = rbin[AW-1:0];

    // mode capture: only while reset is held
    always_ff @(posedge rclk) begin
        if (!mrst_n) mode_q <= fifo_mode_e'(mode_i);
    end

    // state register
    always_ff @(posedge rclk or negedge mrst_n) begin
        if (!mrst_n) state <= RD_RESET;
        else         state <= state_nx;
    end

    // next state and pop decision
    always_comb begin
        state_nx = state;
        pop      = 1'b0;
        unique case (state)
            RD_RESET:    state_nx = (mode_q == MODE_FWFT) ? RD_FW_EMPTY : RD_STD;
            RD_STD:      pop = !ren_n && !mem_empty;
            RD_FW_EMPTY: begin
                if (!mem_empty) begin
                    pop      = 1'b1;
                    state_nx = RD_FW_HOLD;
                end
            end
            RD_FW_HOLD: begin
                if (!ren_n) begin
                    pop      = !mem_empty;
                    state_nx = mem_empty ? RD_FW_EMPTY : RD_FW_HOLD;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        rd_stat = 1'b0;
        unique case (state)
            RD_RESET:    rd_stat = (mode_q == MODE_FWFT);
            RD_STD:      rd_stat = !mem_empty;
            RD_FW_EMPTY: rd_stat = 1'b1;
            RD_FW_HOLD:  rd_stat = 1'b0;
        endcase
        aempty_n = !(mem_cnt <= n_q);
    end

    assign rbin_nx = rbin + (AW+1)'(pop);

    always_ff @(posedge rclk or negedge mrst_n) begin
        if (!mrst_n) begin
            rbin  <= '0;
            rgray <= '0;
            dout  <= '0;
            n_q   <= OFF_N;
        end else begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
            n_q   <= n_q;
            if (pop) dout <= rdata;
        end
    end

    assert_mode_locked_R1: assert property (@(posedge rclk) disable iff (!mrst_n)
        $past(mrst_n) |-> $stable(mode_q));

    assert_std_hold_R2: assert property (@(posedge rclk) disable iff (!mrst_n)
        (state == RD_STD && (ren_n || mem_empty)) |=> $stable(dout));

    assert_fw_hold_R3: assert property (@(posedge rclk) disable iff (!mrst_n)
        (state == RD_FW_HOLD && ren_n) |=> (state == RD_FW_HOLD && $stable(dout)));

    assert_no_underflow_R9: assert property (@(posedge rclk) disable iff (!mrst_n)
        (mem_empty && state != RD_FW_EMPTY) |=> $stable(rbin));

    assert_count_bound_R9: assert property (@(posedge rclk) disable iff (!mrst_n)
        mem_cnt <= DEPTH_P);
endmodule

// File: rtl/fifo_dual_clock.sv
`timescale 1ns/1ps
module fifo_dual_clock #(
    parameter int WIDTH    = 8,
    parameter int DEPTH    = 16,
    parameter int OFFSET_N = 2,
    parameter int OFFSET_M = 3
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             mrst_n,
    input  logic             mode_fwft,
    input  logic             wen_n,
    input  logic [WIDTH-1:0] din,
    input  logic             ren_n,
    output logic [WIDTH-1:0] dout,
    output logic             rd_stat,
    output logic             wr_full_n,
    output logic             almost_empty_n,
    output logic             almost_full_n
);
    localparam int AW = $clog2(DEPTH);

    logic [AW:0]      wgray, rgray, wgray_s, rgray_s;
    logic [AW-1:0]    waddr, raddr;
    logic [WIDTH-1:0] rdata;
    logic             push;

    dual_ram #(.W(WIDTH), .AW(AW)) u_ram (
        .wclk(wclk), .we(push), .waddr(waddr), .wdata(din),
        .raddr(raddr), .rdata(rdata)
    );

    sync_stages #(.W(AW+1), .STAGES(2)) u_sync_w2r (
        .clk(rclk), .rst_n(mrst_n), .d(wgray), .q(wgray_s)
    );

    sync_stages #(.W(AW+1), .STAGES(2)) u_sync_r2w (
        .clk(wclk), .rst_n(mrst_n), .d(rgray), .q(rgray_s)
    );

    fifo_wr_ctl #(.AW(AW), .OFFSET_M(OFFSET_M)) u_wr (
        .wclk(wclk), .mrst_n(mrst_n), .wen_n(wen_n), .rgray_sync(rgray_s),
        .wgray(wgray), .waddr(waddr), .push(push),
        .full_n(wr_full_n), .afull_n(almost_full_n)
    );

    fifo_rd_ctl #(.W(WIDTH), .AW(AW), .OFFSET_N(OFFSET_N)) u_rd (
        .rclk(rclk), .mrst_n(mrst_n), .mode_i(mode_fwft), .ren_n(ren_n),
        .wgray_sync(wgray_s), .rdata(rdata), .raddr(raddr), .rgray(rgray),
        .dout(dout), .rd_stat(rd_stat), .aempty_n(almost_empty_n)
    );
endmodule

// File: tb/tb_fifo_dual_clock.sv
`timescale 1ns/1ps
module tb_fifo_dual_clock;
    localparam int W = 8, D = 16, N = 2, M = 3;
    localparam int NV = 10;
    // each row: words to write, words to read, expected occupancy afterwards
    localparam int TBL [NV][3] = '{
        '{2, 0, 2}, '{1, 0, 3}, '{0, 1, 2}, '{11, 0, 13}, '{0, 1, 12},
        '{1, 0, 13}, '{1, 0, 14}, '{0, 11, 3}, '{0, 1, 2}, '{0, 2, 0}
    };

    logic wclk = 0, rclk = 0;
    logic mrst_n = 0, mode_fwft = 0, wen_n = 1, ren_n = 1;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic rd_stat, wr_full_n, almost_empty_n, almost_full_n;

    always #4 wclk = ~wclk;
    initial begin #3; forever #4 rclk = ~rclk; end

    fifo_dual_clock #(.WIDTH(W), .DEPTH(D), .OFFSET_N(N), .OFFSET_M(M)) dut (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .mode_fwft(mode_fwft),
        .wen_n(wen_n), .din(din), .ren_n(ren_n), .dout(dout),
        .rd_stat(rd_stat), .wr_full_n(wr_full_n),
        .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
    );

    int errors = 0, checks = 0;
    bit done = 0, fw = 0;
    logic [W-1:0] sb [$];
    logic [W-1:0] wval = 8'h10, last = '0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int cap();
        return fw ? D + 1 : D;
    endfunction

    task automatic settle();
        repeat (8) @(negedge rclk);
    endtask

    task automatic do_reset(bit m);
        mrst_n = 0; mode_fwft = m; fw = m; wen_n = 1; ren_n = 1;
        sb.delete(); last = '0;
        repeat (4) @(negedge wclk);
        mrst_n = 1;
        settle();
    endtask

    task automatic write_n(int k);
        for (int i = 0; i < k; i++) begin
            @(negedge wclk);
            din = wval; wen_n = 0;
            if (sb.size() < cap()) sb.push_back(wval);
            wval++;
        end
        @(negedge wclk) wen_n = 1;
    endtask

    task automatic read_n(int k);
        for (int i = 0; i < k; i++) begin
            @(negedge rclk);
            if (fw) begin
                if (sb.size() > 0) begin
                    last = sb.pop_front();
                    check("R10", dout, last, "fall-through order");
                end else begin
                    check("R9", rd_stat, 1, "ready flag on empty read");
                    check("R9", dout, last, "dout held on empty read");
                end
                ren_n = 0;
                @(negedge rclk) ren_n = 1;
            end else begin
                ren_n = 0;
                @(negedge rclk) ren_n = 1;
                if (sb.size() > 0) begin
                    last = sb.pop_front();
                    check("R2", dout, last, "requested word order");
                end else begin
                    check("R9", dout, last, "dout held on empty read");
                    check("R9", rd_stat, 0, "empty flag on empty read");
                end
            end
        end
    endtask

    task automatic check_flags(int occ);
        check(fw ? "R5" : "R4", rd_stat, fw ? (occ > 0 ? 0 : 1) : (occ > 0 ? 1 : 0), "data flag");
        check(fw ? "R5" : "R4", wr_full_n, occ >= cap() ? 0 : 1, "space flag");
        check("R6", almost_empty_n, occ >= (fw ? N + 2 : N + 1) ? 1 : 0, "almost empty");
        check("R7", almost_full_n, occ >= (fw ? D + 1 - M : D - M) ? 0 : 1, "almost full");
        if (fw && occ > 0) check("R3", dout, sb[0], "head word on dout");
    endtask

    initial begin
        repeat (100000) @(posedge wclk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // vector table in both modes
        for (int m = 0; m < 2; m++) begin
            do_reset(m[0]);
            check("R1", rd_stat, m, "reset data flag");
            check_flags(0);
            for (int i = 0; i < NV; i++) begin
                write_n(TBL[i][0]);
                read_n(TBL[i][1]);
                settle();
                check_flags(TBL[i][2]);
            end
        end

        // standard mode: mode pin ignored after reset, no fall-through
        do_reset(0);
        check("R2", dout, 0, "dout after reset");
        mode_fwft = 1;
        write_n(1);
        settle();
        check("R1", rd_stat, 1, "still standard empty flag");
        check("R2", dout, 0, "no word without request");
        read_n(1);
        read_n(2);
        settle();
        check_flags(0);
        // standard full and release
        write_n(20);
        settle();
        check_flags(16);
        check("R8", wr_full_n, 0, "full after DEPTH writes");
        read_n(1);
        settle();
        check("R8", wr_full_n, 1, "first read releases full");
        read_n(16);
        settle();
        check_flags(0);

        // fall-through: exact latency, mode pin ignored after reset
        do_reset(1);
        mode_fwft = 0;
        @(negedge wclk);
        din = wval; wen_n = 0; sb.push_back(wval); wval++;
        @(posedge wclk);
        #1 wen_n = 1;
        repeat (2) @(posedge rclk);
        #1 check("R3", rd_stat, 1, "not ready before third edge");
        @(posedge rclk);
        #1 check("R3", rd_stat, 0, "ready at third edge");
        check("R3", dout, sb[0], "word fell through");
        check("R1", rd_stat, 0, "mode kept after reset");
        settle();
        check_flags(1);
        // fall-through full at DEPTH+1 and release
        write_n(20);
        settle();
        check_flags(17);
        check("R8", wr_full_n, 0, "full after DEPTH+1 words");
        read_n(1);
        settle();
        check("R8", wr_full_n, 1, "first read releases input ready");
        read_n(17);
        settle();
        check_flags(0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule